// File: doc/BRIEF.md
# In-order floating-point issue tracker

This block sequences instructions through a coprocessor pipeline built from a single read-stage register, an execute phase whose length depends on the operation, and a write-back register. Instructions reach it already decoded. Each one carries a three-bit operation class, a precision bit and an opaque tag. The block does not model the arithmetic. It counts each instruction's execute latency, decides when the instruction waiting in the read stage may enter execution, and sends tags out of the write-back register strictly in the order they were accepted.

Up to a parameterised number of instructions (four by default) may execute at once, each tracked in a slot. Two structural hazards hold the read stage. The first is a full slot table. The second is the single iterative divide unit, which is not pipelined. A divide waiting behind another divide may start in the last execute cycle of the one ahead, so the unit never sits idle between two back-to-back divides. Operations with short latency are fully pipelined and can pass through at one per cycle.

Top module: `fpit_tracker`

## Requirements
- R1: A synchronous active-high reset empties the read stage and every tracker slot. In the cycle after reset is released, issue_ready is 1 and wb_valid is 0. Any instruction accepted before the reset never reaches write-back.
- R2: An instruction is accepted in a cycle where issue_valid and issue_ready are both 1. issue_ready is 1 whenever the read stage is empty or its instruction is being dispatched in that cycle. An instruction that cannot be dispatched keeps its place and its tag in the read stage.
- R3: With no hazard, an instruction of latency L accepted in cycle a spends cycle a+1 in the read stage and cycles a+2 to a+L+1 in execution. wb_valid is 1 with its tag during cycle a+L+2.
- R4: Latency is selected by issue_op and issue_dbl (0 = single, 1 = double). Codes 0 (add), 1 (subtract) and 2 (multiply) take 4. Codes 3 (move) and 4 (compare) take 1. Code 5 (divide) takes 8 single or 12 double. Code 6 (square root) takes 10 single or 13 double. Code 7 is reserved and takes 1. All values are parameters.
- R5: Operations of latency 4 or less issued back to back are accepted on consecutive cycles and write back on consecutive cycles.
- R6: Write-back follows acceptance order. An instruction that finishes early waits in its slot until every older instruction has written back. wb_valid is 1 for at most one instruction per cycle.
- R7: At most four instructions are in execution or waiting to write back. A fifth waits in the read stage. It dispatches on the same edge that the oldest slot retires. For five instructions of equal latency L issued back to back, the fifth writes back exactly L cycles after the first.
- R8: Only one divide is in the divide unit at a time. A second divide dispatches in the first divide's last execute cycle, so two back-to-back divides of latency L write back exactly L cycles apart.
- R9: Square root and all non-divide operations are not held by a busy divide unit. A square root accepted the cycle after a divide starts on time and meets its own R3 latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| issue_valid | input | 1 | An instruction is offered |
| issue_ready | output | 1 | The read stage can take the offered instruction this cycle |
| issue_op | input | 3 | Operation class code (see R4) |
| issue_dbl | input | 1 | Precision: 0 single, 1 double |
| issue_tag | input | TAG_W | Opaque tag carried to write-back |
| wb_valid | output | 1 | One instruction is in write-back this cycle |
| wb_tag | output | TAG_W | Tag of the instruction in write-back |

## Verification
The bench targets the handoff between two divides. A design that waits for the first divide to retire would spread their write-backs by more than L cycles, and one that ignores the busy unit would spread them by one. It fills the tracker with long square roots. A design that does not reuse a slot on the retire edge delays the fifth write-back by a cycle, and one that lets a fifth entry in writes it back early. A short move placed behind a long divide catches any design that lets a finished instruction overtake an older one. A reset in the middle of a busy stream must leave no stray write-back afterwards.

// File: rtl/fpit_pkg.sv
package fpit_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_MUL  = 3'd2,
    OP_MOV  = 3'd3,
    OP_CMP  = 3'd4,
    OP_DIV  = 3'd5,
    OP_SQRT = 3'd6,
    OP_RSVD = 3'd7
  } fpit_op_e;

  function automatic int unsigned fpit_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fpit_latency.sv
// Maps an operation class and precision to its execute latency (R4).
module fpit_latency
  import fpit_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int LAT_ARITH   = 4,
  parameter int LAT_MOVE    = 1,
  parameter int LAT_DIV_SP  = 8,
  parameter int LAT_DIV_DP  = 12,
  parameter int LAT_SQRT_SP = 10,
  parameter int LAT_SQRT_DP = 13
) (
  input  logic [2:0]       op,
  input  logic             dbl,
  output logic [CNT_W-1:0] lat
);

  always_comb begin
    case (fpit_op_e'(op))
      OP_ADD, OP_SUB, OP_MUL: lat = CNT_W'(LAT_ARITH);
      OP_MOV, OP_CMP:         lat = CNT_W'(LAT_MOVE);
      OP_DIV:                 lat = dbl ? CNT_W'(LAT_DIV_DP)  : CNT_W'(LAT_DIV_SP);
      OP_SQRT:                lat = dbl ? CNT_W'(LAT_SQRT_DP) : CNT_W'(LAT_SQRT_SP);
      default:                lat = CNT_W'(LAT_MOVE);
    endcase
  end

endmodule

// File: rtl/fpit_read_stage.sv
// Single-entry read stage holding one decoded instruction (R2).
module fpit_read_stage #(
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             dispatch,
  input  logic [2:0]       in_op,
  input  logic             in_dbl,
  input  logic [TAG_W-1:0] in_tag,
  output logic             rd_valid,
  output logic [2:0]       rd_op,
  output logic             rd_dbl,
  output logic [TAG_W-1:0] rd_tag
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
    end else if (accept) begin
      rd_valid <= 1'b1;
    end else if (dispatch) begin
      rd_valid <= 1'b0;
    end
  end

  // Payload carries no reset; it is only meaningful while rd_valid is set.
  always_ff @(posedge clk) begin
    if (accept) begin
      rd_op  <= in_op;
      rd_dbl <= in_dbl;
      rd_tag <= in_tag;
    end
  end

endmodule

// File: rtl/fpit_div_unit.sv
// Occupancy counter of the single iterative divide unit (R8).
module fpit_div_unit #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] lat,
  output logic [CNT_W-1:0] remaining
);

  // remaining reads 1 during the last execute cycle of the divide in the unit.
  always_ff @(posedge clk) begin
    if (rst) begin
      remaining <= '0;
    end else if (start) begin
      remaining <= lat;
    end else if (remaining != '0) begin
      remaining <= remaining - CNT_W'(1);
    end
  end

endmodule

// File: rtl/fpit_slot_table.sv
// In-order table of in-flight instructions with a latency counter per slot (R6, R7).
module fpit_slot_table #(
  parameter int SLOTS = 4,
  parameter int TAG_W = 8,
  parameter int CNT_W = 4,
  parameter int OCC_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [TAG_W-1:0] push_tag,
  input  logic [CNT_W-1:0] push_lat,
  output logic             retire,
  output logic [TAG_W-1:0] retire_tag,
  output logic [OCC_W-1:0] occ
);

  localparam int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [TAG_W-1:0] tag_mem [SLOTS];
  logic [CNT_W-1:0] cnt_q   [SLOTS];
  logic [SLOTS-1:0] live_q;
  logic [SLOTS-1:0] done_vec;
  logic [PTR_W-1:0] head_q, tail_q;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(SLOTS - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  // A slot is done once its counter has drained to zero.
  for (genvar g = 0; g < SLOTS; g++) begin : g_done
    assign done_vec[g] = live_q[g] && (cnt_q[g] == '0);
  end

  // Only the oldest slot may leave, which keeps write-back in issue order.
  assign retire     = done_vec[head_q];
  assign retire_tag = tag_mem[head_q];

  // Tag store: one write port, asynchronous read of the head entry.
  always_ff @(posedge clk) begin
    if (push) begin
      tag_mem[tail_q] <= push_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= '0;
      head_q <= '0;
      tail_q <= '0;
      occ    <= '0;
      for (int i = 0; i < SLOTS; i++) begin
        cnt_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        if (push && (tail_q == PTR_W'(i))) begin
          // A push onto the slot retiring this cycle wins that slot.
          live_q[i] <= 1'b1;
          cnt_q[i]  <= push_lat - CNT_W'(1);
        end else if (retire && (head_q == PTR_W'(i))) begin
          live_q[i] <= 1'b0;
        end else if (live_q[i] && (cnt_q[i] != '0)) begin
          cnt_q[i] <= cnt_q[i] - CNT_W'(1);
        end
      end
      if (push) begin
        tail_q <= ptr_next(tail_q);
      end
      if (retire) begin
        head_q <= ptr_next(head_q);
      end
      case ({push, retire})
        2'b10:   occ <= occ + OCC_W'(1);
        2'b01:   occ <= occ - OCC_W'(1);
        default: occ <= occ;
      endcase
    end
  end

endmodule

// File: rtl/fpit_tracker.sv
// Issue, dispatch and in-order retirement control for a floating-point coprocessor pipeline.
module fpit_tracker
  import fpit_pkg::*;
#(
  parameter int TAG_W       = 8,
  parameter int SLOTS       = 4,
  parameter int LAT_ARITH   = 4,
  parameter int LAT_MOVE    = 1,
  parameter int LAT_DIV_SP  = 8,
  parameter int LAT_DIV_DP  = 12,
  parameter int LAT_SQRT_SP = 10,
  parameter int LAT_SQRT_DP = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue_valid,
  output logic             issue_ready,
  input  logic [2:0]       issue_op,
  input  logic             issue_dbl,
  input  logic [TAG_W-1:0] issue_tag,
  output logic             wb_valid,
  output logic [TAG_W-1:0] wb_tag
);

  localparam int LAT_MAX = fpit_max(fpit_max(fpit_max(LAT_ARITH, LAT_MOVE),
                                             fpit_max(LAT_DIV_SP, LAT_DIV_DP)),
                                    fpit_max(LAT_SQRT_SP, LAT_SQRT_DP));
  localparam int CNT_W   = $clog2(LAT_MAX + 1);
  localparam int OCC_W   = $clog2(SLOTS + 1);

  logic             rd_valid;
  logic [2:0]       rd_op;
  logic             rd_dbl;
  logic [TAG_W-1:0] rd_tag;
  logic [CNT_W-1:0] rd_lat;
  logic [CNT_W-1:0] div_rem;
  logic             div_blocked;
  logic             rd_is_div;
  logic             slot_free;
  logic             retire;
  logic [TAG_W-1:0] retire_tag;
  logic [OCC_W-1:0] occ;
  logic             dispatch;
  logic             accept;

  fpit_read_stage #(.TAG_W(TAG_W)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .dispatch (dispatch),
    .in_op    (issue_op),
    .in_dbl   (issue_dbl),
    .in_tag   (issue_tag),
    .rd_valid (rd_valid),
    .rd_op    (rd_op),
    .rd_dbl   (rd_dbl),
    .rd_tag   (rd_tag)
  );

  fpit_latency #(
    .CNT_W       (CNT_W),
    .LAT_ARITH   (LAT_ARITH),
    .LAT_MOVE    (LAT_MOVE),
    .LAT_DIV_SP  (LAT_DIV_SP),
    .LAT_DIV_DP  (LAT_DIV_DP),
    .LAT_SQRT_SP (LAT_SQRT_SP),
    .LAT_SQRT_DP (LAT_SQRT_DP)
  ) u_lat (
    .op  (rd_op),
    .dbl (rd_dbl),
    .lat (rd_lat)
  );

  fpit_div_unit #(.CNT_W(CNT_W)) u_div (
    .clk       (clk),
    .rst       (rst),
    .start     (dispatch && rd_is_div),
    .lat       (rd_lat),
    .remaining (div_rem)
  );

  fpit_slot_table #(
    .SLOTS (SLOTS),
    .TAG_W (TAG_W),
    .CNT_W (CNT_W),
    .OCC_W (OCC_W)
  ) u_tab (
    .clk        (clk),
    .rst        (rst),
    .push       (dispatch),
    .push_tag   (rd_tag),
    .push_lat   (rd_lat),
    .retire     (retire),
    .retire_tag (retire_tag),
    .occ        (occ)
  );

  // R8: the divide unit frees up for a successor in its last execute cycle.
  assign rd_is_div   = (rd_op == OP_DIV);
  assign div_blocked = (div_rem > CNT_W'(1));
  // R7: a slot is available if the table is short or its head leaves this cycle.
  assign slot_free   = (occ != OCC_W'(SLOTS)) || retire;
  assign dispatch    = rd_valid && slot_free && !(rd_is_div && div_blocked);
  // R2
  assign issue_ready = !rd_valid || dispatch;
  assign accept      = issue_valid && issue_ready;

  // Write-back register (R3, R6).
  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid <= 1'b0;
    end else begin
      wb_valid <= retire;
    end
  end

  always_ff @(posedge clk) begin
    if (retire) begin
      wb_tag <= retire_tag;
    end
  end

endmodule

// File: rtl/fpit_tracker_chk.sv
module fpit_tracker_chk
  import fpit_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int CNT_W = 4,
  parameter int OCC_W = 3,
  parameter int SLOTS = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             issue_ready,
  input logic             rd_valid,
  input logic [TAG_W-1:0] rd_tag,
  input logic [2:0]       rd_op,
  input logic             dispatch,
  input logic [OCC_W-1:0] occ,
  input logic             retire,
  input logic [CNT_W-1:0] div_rem
);

  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> issue_ready); // R2

  AST_RD_HOLDS_TAG: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !dispatch) |=> (rd_valid && $stable(rd_tag))); // R2

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (rst)
    occ <= OCC_W'(SLOTS)); // R7

  AST_FULL_STALL: assert property (@(posedge clk) disable iff (rst)
    ((occ == OCC_W'(SLOTS)) && !retire) |-> !dispatch); // R7

  AST_DIV_HANDOFF: assert property (@(posedge clk) disable iff (rst)
    (dispatch && (rd_op == OP_DIV)) |-> (div_rem <= CNT_W'(1))); // R8

endmodule

bind fpit_tracker fpit_tracker_chk #(
  .TAG_W (TAG_W),
  .CNT_W (CNT_W),
  .OCC_W (OCC_W),
  .SLOTS (SLOTS)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .issue_ready (issue_ready),
  .rd_valid    (rd_valid),
  .rd_tag      (rd_tag),
  .rd_op       (rd_op),
  .dispatch    (dispatch),
  .occ         (occ),
  .retire      (retire),
  .div_rem     (div_rem)
);

// File: tb/fpit_tracker_tb_top.sv
module fpit_tracker_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       issue_valid = 1'b0;
  logic [2:0] issue_op = 3'd0;
  logic       issue_dbl = 1'b0;
  logic [7:0] issue_tag = 8'd0;
  logic       issue_ready;
  logic       wb_valid;
  logic [7:0] wb_tag;

  always #5 clk = ~clk;

  fpit_tracker dut_i (
    .clk         (clk),
    .rst         (rst),
    .issue_valid (issue_valid),
    .issue_ready (issue_ready),
    .issue_op    (issue_op),
    .issue_dbl   (issue_dbl),
    .issue_tag   (issue_tag),
    .wb_valid    (wb_valid),
    .wb_tag      (wb_tag)
  );

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 0;

  // Behavioural reference state
  bit m_rv;
  int m_rop;
  bit m_rdbl;
  int m_rtag;
  int m_qt[$];
  int m_qr[$];
  int m_div;
  bit m_wbv;
  int m_wbt;
  int order_q[$];
  int acc_cyc[256];
  int wb_cyc[256];

  function automatic int lat_of(input int op, input bit dbl);
    case (op)
      0, 1, 2: return 4;
      3, 4:    return 1;
      5:       return dbl ? 12 : 8;
      6:       return dbl ? 13 : 10;
      default: return 1;
    endcase
  endfunction

  function automatic bit m_retire();
    return (m_qt.size() > 0) && (m_qr[0] == 0);
  endfunction

  function automatic bit m_disp();
    return m_rv && ((m_qt.size() < 4) || m_retire()) && !((m_rop == 5) && (m_div > 1));
  endfunction

  function automatic bit m_ready();
    return !m_rv || m_disp();
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic model_clear();
    m_rv = 0;
    m_qt.delete();
    m_qr.delete();
    m_div = 0;
    m_wbv = 0;
    m_wbt = 0;
    order_q.delete();
  endtask

  task automatic tick(input bit iv, input int op, input bit dbl, input int tag, output bit acc);
    bit ret;
    bit dsp;
    @(negedge clk);
    cyc++;
    check(issue_ready === m_ready(), "R2", "issue_ready", int'(issue_ready), int'(m_ready()));
    check(wb_valid === m_wbv, "R6", "wb_valid", int'(wb_valid), int'(m_wbv));
    if (wb_valid === 1'b1) begin
      wb_cyc[wb_tag] = cyc;
      if (m_wbv) check(int'(wb_tag) == m_wbt, "R6", "wb_tag vs model", int'(wb_tag), m_wbt);
      if (order_q.size() == 0) begin
        check(1'b0, "R6", "write-back with nothing outstanding", int'(wb_tag), -1);
      end else begin
        check(int'(wb_tag) == order_q[0], "R6", "retire order", int'(wb_tag), order_q[0]);
        void'(order_q.pop_front());
      end
    end
    issue_valid = iv;
    issue_op    = 3'(op);
    issue_dbl   = dbl;
    issue_tag   = 8'(tag);
    acc = iv && m_ready();
    if (acc) begin
      order_q.push_back(tag);
      acc_cyc[tag] = cyc;
    end
    ret = m_retire();
    dsp = m_disp();
    m_wbv = ret;
    if (ret) begin
      m_wbt = m_qt.pop_front();
      void'(m_qr.pop_front());
    end
    foreach (m_qr[i]) if (m_qr[i] > 0) m_qr[i]--;
    if (m_div > 0) m_div--;
    if (dsp) begin
      int l;
      l = lat_of(m_rop, m_rdbl);
      m_qt.push_back(m_rtag);
      m_qr.push_back(l - 1);
      if (m_rop == 5) m_div = l;
      m_rv = 0;
    end
    if (acc) begin
      m_rv   = 1;
      m_rop  = op;
      m_rdbl = dbl;
      m_rtag = tag;
    end
  endtask

  task automatic send(input int op, input bit dbl, input int tag);
    bit a;
    do tick(1'b1, op, dbl, tag, a); while (!a);
  endtask

  task automatic idle(input int n);
    bit a;
    for (int i = 0; i < n; i++) tick(1'b0, 0, 1'b0, 0, a);
  endtask

  task automatic drain();
    bit a;
    while (m_rv || (m_qt.size() != 0) || m_wbv) tick(1'b0, 0, 1'b0, 0, a);
    idle(2);
  endtask

  task automatic do_reset(input int n);
    @(negedge clk);
    issue_valid = 1'b0;
    rst = 1'b1;
    repeat (n) @(negedge clk);
    rst = 1'b0;
    cyc++;
    model_clear();
    // R1: empty pipeline right after reset
    check(issue_ready === 1'b1, "R1", "issue_ready after reset", int'(issue_ready), 1);
    check(wb_valid === 1'b0, "R1", "wb_valid after reset", int'(wb_valid), 0);
  endtask

  initial begin
    model_clear();
    do_reset(3);
    idle(3);

    // R3 and R4: isolated latency of every class at both precisions
    for (int op = 0; op < 8; op++) begin
      for (int d = 0; d < 2; d++) begin
        int t;
        t = 100 + op * 2 + d;
        send(op, d[0], t);
        drain();
        check(wb_cyc[t] - acc_cyc[t] == lat_of(op, d[0]) + 2, (op == 0) ? "R3" : "R4",
              "accept-to-writeback cycles", wb_cyc[t] - acc_cyc[t], lat_of(op, d[0]) + 2);
      end
    end

    // R5: back-to-back short operations
    for (int k = 0; k < 6; k++) send((k % 2 == 0) ? 0 : 2, k[0], 20 + k);
    drain();
    check(acc_cyc[25] - acc_cyc[20] == 5, "R5", "accept span of 6 adds", acc_cyc[25] - acc_cyc[20], 5);
    check(wb_cyc[25] - wb_cyc[20] == 5, "R5", "write-back span of 6 adds", wb_cyc[25] - wb_cyc[20], 5);

    // R8: divide handoff, single then double
    send(5, 1'b0, 40);
    send(5, 1'b0, 41);
    drain();
    check(wb_cyc[41] - wb_cyc[40] == 8, "R8", "single divide spacing", wb_cyc[41] - wb_cyc[40], 8);
    send(5, 1'b1, 42);
    send(5, 1'b1, 43);
    drain();
    check(wb_cyc[43] - wb_cyc[42] == 12, "R8", "double divide spacing", wb_cyc[43] - wb_cyc[42], 12);

    // R9: square root behind a busy divide
    send(5, 1'b0, 44);
    send(6, 1'b1, 45);
    drain();
    check(acc_cyc[45] - acc_cyc[44] == 1, "R9", "sqrt accept after divide", acc_cyc[45] - acc_cyc[44], 1);
    check(wb_cyc[45] - acc_cyc[45] == 15, "R9", "sqrt latency behind divide", wb_cyc[45] - acc_cyc[45], 15);

    // R6: short move finishing early behind a divide
    send(5, 1'b0, 50);
    send(3, 1'b0, 51);
    drain();
    check(wb_cyc[51] - wb_cyc[50] == 1, "R6", "move waits for older divide", wb_cyc[51] - wb_cyc[50], 1);

    // R7: six single square roots fill the tracker
    for (int k = 0; k < 6; k++) send(6, 1'b0, 60 + k);
    drain();
    check(wb_cyc[61] - wb_cyc[60] == 1, "R7", "2nd sqrt after 1st", wb_cyc[61] - wb_cyc[60], 1);
    check(wb_cyc[63] - wb_cyc[60] == 3, "R7", "4th sqrt after 1st", wb_cyc[63] - wb_cyc[60], 3);
    check(wb_cyc[64] - wb_cyc[60] == 10, "R7", "5th sqrt after 1st", wb_cyc[64] - wb_cyc[60], 10);
    check(wb_cyc[65] - wb_cyc[61] == 10, "R7", "6th sqrt after 2nd", wb_cyc[65] - wb_cyc[61], 10);

    // Mixed random stream compared against the model every cycle
    for (int k = 0; k < 400; k++) begin
      send(int'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), k % 256);
      if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 3)));
    end
    drain();

    // R1: reset in the middle of a busy stream
    send(6, 1'b1, 200);
    send(5, 1'b1, 201);
    send(5, 1'b1, 202);
    send(0, 1'b0, 203);
    idle(2);
    do_reset(2);
    idle(30);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule